// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current of a three-phase bridge in which only two legs conduct at a time. A commutation pattern names a source leg, whose high-side switch is on, and a sink leg, whose low-side switch closes the path to ground. A comparator flag reports that the sensed current has crossed its reference. The block then opens the sink low-side switch and holds it open for a programmed off time. During that interval the current circulates through the upper half of the bridge, and the sink leg's upper switch conducts synchronously once a dead time has passed.

All timing is counted in clock cycles and supplied at run time: off time, dead time, comparator blanking and minimum on time. After every low-side turn-on, the comparator is masked for the blanking window. A trip is never acted on before the minimum on time has elapsed. A new commutation pattern is picked up only at the boundary of an off period. Any leg whose switches change over always waits at least one dead time.

Top module: `chop_ctrl`

## Requirements
- R1: Synchronous active-high reset forces every gate enable low. After reset is released, the first low-side turn-on comes `dead_cyc` cycles after the release, with all enables low until then.
- R2: In the on phase, `hs_en` has only the source leg's bit set and `ls_en` has only the sink leg's bit set. The third leg keeps both of its enables low in every phase.
- R3: A trip opens the sink low-side switch in the cycle after the edge that sampled it. The source high-side switch stays on.
- R4: The sink leg's high-side switch turns on once the dead time has passed. The off timer starts at the trip, so this switch stays on for `off_cyc - dead_cyc` cycles when `off_cyc > dead_cyc`, and for one cycle otherwise.
- R5: After the synchronous switch opens, the low side closes again only after a further `dead_cyc` cycles. The low side is therefore open for `off_cyc + dead_cyc` cycles in total.
- R6: During the first `blank_cyc` cycles of each on phase, `sense_hi` has no effect. With the flag held high throughout, the on phase lasts `max(blank_cyc + 1, min_on_cyc)` cycles.
- R7: An on phase lasts at least `min_on_cyc` cycles. A trip seen after blanking but before that count is reached is held, and it ends the on phase exactly when the minimum is met, even if the flag has since dropped.
- R8: The high-side and low-side enables of one leg are never both high in the same cycle. A leg's high side never turns on in the cycle right after its low side was on, and the reverse also holds.
- R9: The commutation inputs are sampled at the end of each off timer, or continuously while no valid pattern is active. The new pattern drives the gates from the next on phase onward. A source high-side switch that is not part of the new pattern opens at the start of the final dead time.
- R10: An invalid pattern (source equal to sink, or either code equal to 3) keeps all six enables low until a valid pattern is picked up.
- R11: Leg code n (0, 1 or 2) selects bit n of `hs_en` and `ls_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_hi | input | 1 | Comparator flag: sensed current above reference |
| src_leg | input | 2 | Leg code driven high (0..2, 3 = none) |
| snk_leg | input | 2 | Leg code driven low (0..2, 3 = none) |
| off_cyc | input | CW | Off-timer length in cycles, counted from the trip |
| dead_cyc | input | CW | Dead time in cycles |
| blank_cyc | input | CW | Comparator blanking after low-side turn-on |
| min_on_cyc | input | CW | Minimum on-phase length |
| hs_en | output | 3 | High-side gate enables, one bit per leg |
| ls_en | output | 3 | Low-side gate enables, one bit per leg |

## Verification
Some properties are checked by assertions on every cycle. No leg ever has both enables high. At most one low side and two high sides are on at once. No switch closes in the cycle right after its partner in the same leg was on. Every low-side conduction run is checked against the minimum on time and the blanking window.

The remaining properties can only be shown by scenarios comparing the ports with a behavioural model on each clock:
- the exact off-gap and synchronous-rectification lengths;
- a held trip ending an on phase at the minimum;
- a pulse inside the blanking window being ignored;
- a pattern change waiting for the next on phase;
- recovery from an invalid pattern.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sense_hi,
  input  logic [1:0]    src_leg,
  input  logic [1:0]    snk_leg,
  input  logic [CW-1:0] off_cyc,
  input  logic [CW-1:0] dead_cyc,
  input  logic [CW-1:0] blank_cyc,
  input  logic [CW-1:0] min_on_cyc,
  output logic [2:0]    hs_en,
  output logic [2:0]    ls_en
);

  localparam logic [1:0] NONE = 2'd3;

  typedef enum logic [1:0] {S_ON, S_DT1, S_SYN, S_DT2} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          pend;
  logic [1:0]    c_src, c_snk, n_src, n_snk;

  function automatic logic [2:0] oh(input logic [1:0] i);
    return 3'b001 << i;
  endfunction

  wire cur_ok = (c_src != NONE) && (c_snk != NONE) && (c_src != c_snk);
  wire nxt_ok = (n_src != NONE) && (n_snk != NONE) && (n_src != n_snk);

  wire [CW:0]   cnt1      = {1'b0, cnt} + (CW+1)'(1);
  wire [CW-1:0] cnt_inc   = (&cnt) ? cnt : cnt + CW'(1);
  wire          dead_done = cnt1 >= {1'b0, dead_cyc};
  wire          off_done  = cnt1 >= {1'b0, off_cyc};
  wire          min_met   = cnt1 >= {1'b0, min_on_cyc};
  wire          sense_ok  = sense_hi && (cnt >= blank_cyc);
  wire          trip      = (pend || sense_ok) && min_met;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_DT2;
      cnt   <= '0;
      pend  <= 1'b0;
      c_src <= NONE;
      c_snk <= NONE;
      n_src <= NONE;
      n_snk <= NONE;
    end else begin
      case (st)
        S_DT2: begin
          if (!cur_ok) begin
            n_src <= src_leg;
            n_snk <= snk_leg;
          end
          if (dead_done) begin
            st    <= S_ON;
            cnt   <= '0;
            pend  <= 1'b0;
            c_src <= n_src;
            c_snk <= n_snk;
          end else cnt <= cnt_inc;
        end
        S_ON: begin
          if (!cur_ok) begin
            st  <= S_DT2;
            cnt <= '0;
          end else if (trip) begin
            st   <= S_DT1;
            cnt  <= '0;
            pend <= 1'b0;
          end else begin
            if (sense_ok) pend <= 1'b1;
            cnt <= cnt_inc;
          end
        end
        S_DT1: begin
          cnt <= cnt_inc;
          if (dead_done) st <= S_SYN;
        end
        default: begin
          if (off_done) begin
            st    <= S_DT2;
            cnt   <= '0;
            n_src <= src_leg;
            n_snk <= snk_leg;
          end else cnt <= cnt_inc;
        end
      endcase
    end
  end

  always_comb begin
    hs_en = 3'b000;
    ls_en = 3'b000;
    if (cur_ok) begin
      case (st)
        S_ON:    begin hs_en = oh(c_src); ls_en = oh(c_snk); end
        S_DT1:   hs_en = oh(c_src);
        S_SYN:   hs_en = oh(c_src) | oh(c_snk);
        default: if (nxt_ok && n_src == c_src) hs_en = oh(c_src);
      endcase
    end
  end

  logic [CW:0] lo_run;
  always_ff @(posedge clk) begin
    if (rst) lo_run <= '0;
    else if (|ls_en) lo_run <= (&lo_run) ? lo_run : lo_run + (CW+1)'(1);
    else lo_run <= '0;
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_en & ls_en) == 3'b000);

  assert_leg_count_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(ls_en) <= 1) && ($countones(hs_en) <= 2));

  assert_min_on_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(|ls_en) |-> lo_run >= {1'b0, min_on_cyc});

  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(|ls_en) |-> lo_run > {1'b0, blank_cyc});

  for (genvar g = 0; g < 3; g++) begin : g_leg
    assert_lo_gap_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(ls_en[g]) |-> !$past(hs_en[g]));
    assert_hi_gap_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_en[g]) |-> !$past(ls_en[g]));
  end

endmodule

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;
  localparam int  CW  = 16;
  localparam time TCK = 10;

  logic clk = 1'b0, rst = 1'b1, sense = 1'b0;
  logic [1:0] src = 2'd0, snk = 2'd1;
  logic [CW-1:0] offc = 16'd10, deadc = 16'd3, blankc = 16'd2, minc = 16'd4;
  wire  [2:0] hs, ls;

  always #(TCK/2) clk = ~clk;

  chop_ctrl #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .sense_hi(sense), .src_leg(src), .snk_leg(snk),
    .off_cyc(offc), .dead_cyc(deadc), .blank_cyc(blankc), .min_on_cyc(minc),
    .hs_en(hs), .ls_en(ls)
  );

  int    n_chk = 0, n_fail = 0;
  string tg = "R1";
  bit    done = 1'b0;

  task automatic chk(input bit c, input string t, input int a, input int e);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, a, e, $time);
    end
  endtask

  // behavioural reference: phase 0 on, 1 first dead, 2 sync, 3 final dead
  int m_ph, m_t, m_hold, m_s, m_k, m_ns, m_nk;

  function automatic bit good(input int s, input int k);
    return (s < 3) && (k < 3) && (s != k);
  endfunction

  always @(posedge clk) begin : model
    int ons, onk;
    bit live;
    if (rst) begin
      m_ph = 3; m_t = 0; m_hold = 0; m_s = 3; m_k = 3; m_ns = 3; m_nk = 3;
    end else begin
      live = good(m_s, m_k);
      ons = m_ns; onk = m_nk;
      if (m_ph == 3) begin
        if (!live) begin m_ns = src; m_nk = snk; end
        if (m_t + 1 >= deadc) begin
          m_ph = 0; m_t = 0; m_hold = 0; m_s = ons; m_k = onk;
        end else m_t++;
      end else if (m_ph == 0) begin
        if (!live) begin m_ph = 3; m_t = 0; end
        else if ((m_hold || (sense && m_t >= blankc)) && (m_t + 1 >= minc)) begin
          m_ph = 1; m_t = 0; m_hold = 0;
        end else begin
          if (sense && m_t >= blankc) m_hold = 1;
          m_t++;
        end
      end else if (m_ph == 1) begin
        if (m_t + 1 >= deadc) m_ph = 2;
        m_t++;
      end else begin
        if (m_t + 1 >= offc) begin
          m_ph = 3; m_t = 0; m_ns = src; m_nk = snk;
        end else m_t++;
      end
    end
  end

  always @(negedge clk) begin : compare
    logic [2:0] eh, el;
    eh = 3'b000; el = 3'b000;
    if (!rst && good(m_s, m_k)) begin
      case (m_ph)
        0: begin eh = 3'(1 << m_s); el = 3'(1 << m_k); end
        1: eh = 3'(1 << m_s);
        2: eh = 3'(1 << m_s) | 3'(1 << m_k);
        default: if (good(m_ns, m_nk) && m_ns == m_s) eh = 3'(1 << m_s);
      endcase
    end
    if (!done) begin
      chk(hs == eh, {tg, " high-side vs model"}, hs, eh);
      chk(ls == el, {tg, " low-side vs model"}, ls, el);
      chk((hs & ls) == 3'b000, "R8 leg overlap", hs & ls, 0);
    end
  end

  task automatic run_off(output int k, output int hk);
    k = 0; hk = 0;
    while (ls == 3'b000 && k < 1000) begin
      k++;
      if (hs[snk_of_prev]) hk++;
      @(negedge clk);
    end
  endtask

  int snk_of_prev = 1;

  task automatic run_on(output int k);
    k = 0;
    while (ls != 3'b000 && k < 1000) begin k++; @(negedge clk); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int k, hk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tg = "R1";
    chk(hs == 0 && ls == 0, "R1 enables low at reset", {hs, ls}, 0);
    run_off(k, hk);
    chk(k == 3, "R1 first on delay", k, 3);

    tg = "R2";
    chk(hs == 3'b001, "R2 source high side", hs, 1);
    chk(ls == 3'b010, "R11 sink low side bit", ls, 2);

    tg = "R6";
    @(negedge clk) sense = 1'b1;
    @(negedge clk) sense = 1'b0;
    repeat (15) @(negedge clk);
    chk(ls == 3'b010, "R6 pulse in blanking ignored", ls, 2);

    tg = "R3";
    sense = 1'b1;
    @(negedge clk) sense = 1'b0;
    chk(ls == 3'b000, "R3 low side opens", ls, 0);
    chk(hs == 3'b001, "R3 source high held", hs, 1);
    minc = 16'd8;
    run_off(k, hk);
    chk(k == 13, "R5 low side off gap", k, 13);
    chk(hk == 7, "R4 sync high-side run", hk, 7);

    tg = "R7";
    repeat (3) @(negedge clk);
    sense = 1'b1;
    @(negedge clk) sense = 1'b0;
    run_on(k);
    chk(k + 4 == 8, "R7 held trip ends at minimum", k + 4, 8);

    tg = "R6";
    blankc = 16'd5; minc = 16'd2; sense = 1'b1;
    run_off(k, hk);
    chk(k == 13, "R5 off gap second pass", k, 13);
    run_on(k);
    chk(k == 6, "R6 on length with flag held", k, 6);
    sense = 1'b0;

    tg = "R9";
    run_off(k, hk);
    repeat (2) @(negedge clk);
    src = 2'd2; snk = 2'd0;
    repeat (10) @(negedge clk);
    chk(ls == 3'b010 && hs == 3'b001, "R9 pattern held in on phase", {hs, ls}, 10);
    sense = 1'b1;
    @(negedge clk) sense = 1'b0;
    run_off(k, hk);
    chk(hs == 3'b100, "R9 new source after off", hs, 4);
    chk(ls == 3'b001, "R11 new sink bit", ls, 1);

    tg = "R10";
    snk_of_prev = 0;
    repeat (8) @(negedge clk);
    src = 2'd1; snk = 2'd1; sense = 1'b1;
    @(negedge clk) sense = 1'b0;
    repeat (40) @(negedge clk);
    chk(hs == 0 && ls == 0, "R10 invalid pattern all off", {hs, ls}, 0);
    src = 2'd1; snk = 2'd2;
    run_off(k, hk);
    chk(ls == 3'b100, "R10 recovery sink", ls, 4);
    chk(hs == 3'b010, "R11 recovery source", hs, 2);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule